// File: doc/BRIEF.md
# Prioritized interrupt request controller

This block gathers request lines from several peripherals and decides which one should interrupt the CPU. Each source owns an 8-bit control register that holds a pending flag and a 3-bit priority level. At build time each source is fixed as edge-recognized or level-recognized. An edge source latches a rising edge of its request line into the pending flag, and software can also set or clear that flag. For a level source, the pending flag simply reflects the request line, and software cannot change it.

A combinational arbiter picks the pending source with the numerically lowest level. Level 7 disables a source, and ties go to the lowest source index. The CPU reads a vector register to learn the winning index. That read clears the winner's flag if the winner is an edge source. The same read copies the winner's level into the 3-bit mask, so equal or less urgent requests stay blocked until software rewrites the mask.

A single registered interrupt line tells the CPU that a winner is below the mask. Once raised, the line stays high until reset, a vector read or a mask write, even if the flag behind it is cleared.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every control register reads 0x07, the mask reads 0x07, the vector reads 0xFF and `cpu_irq` is 0.
- R2: Control register i is at address i, the vector at address 8 and the mask at address 9. In a control register the pending flag is bit 4 and the level is bits [2:0]. Bits 3 and [7:5] read as 0. The level field is writable for every source.
- R3: On an edge source, a rising edge of its request line sets the pending flag at the next clock edge. Holding the line high does not set the flag again.
- R4: On an edge source, a register write with bit 4 = 1 sets the flag and a write with bit 4 = 0 clears it.
- R5: On a level source, the flag reads as the current request line, and writes to bit 4 have no effect.
- R6: If a software clear and a request rising edge occur in the same cycle, the flag ends up 0.
- R7: The vector read returns the index of the pending source with the lowest level below 7, with ties going to the lowest index. It returns 0xFF when no such source exists. A level-7 source never wins.
- R8: A vector read clears the winner's flag when the winner is an edge source, including in a cycle where its request line rises. It leaves a level source's flag unchanged.
- R9: A vector read with a winner loads the winner's level into the mask. A write to address 9 loads bits [2:0] into the mask, and the mask reads back zero-extended.
- R10: `cpu_irq` rises one cycle after a winner exists whose level is strictly below the mask.
- R11: `cpu_irq`, once high, falls only after reset, a vector read or a mask write. Clearing the flag does not drop it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_req | input | NSRC | Raw request lines, one per source |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; the vector read acts at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during `bus_rd` |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
The assertions check the following on every cycle:
- A software clear or a vector-read clear always leaves an edge flag at 0, and a lone rising edge always sets it.
- Any reported winner is pending and enabled.
- A vector read copies the winner's level into the mask.
- `cpu_irq` only rises after an eligible winner, stays high unless a vector read or mask write occurs, and falls after either one.

Only the directed scenarios can show the following:
- The register layout and the reset values.
- The tie-breaking order across sources.
- That a held request line does not set the flag again.
- That level sources ignore writes and vector reads.
- The strict below-mask comparison.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef logic [2:0] lvl_t;

  localparam lvl_t LVL_OFF  = 3'd7;
  localparam int   FLAG_BIT = 4;

  // control byte image: level in [2:0], pending flag in [4], rest zero
  function automatic logic [7:0] pack_ctrl(logic flag, lvl_t lvl);
    return {3'b000, flag, 1'b0, lvl};
  endfunction

  // a request at level a may reach the CPU under mask m
  function automatic logic below_mask(lvl_t a, lvl_t m);
    return a < m;
  endfunction
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_ctrl_pkg::*;
#(
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic wr_sel,
  input  logic wr_flag,
  input  lvl_t wr_lvl,
  input  logic vec_clr,
  output logic flag,
  output lvl_t lvl
);
  lvl_t lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= LVL_OFF;
    else if (wr_sel) lvl_q <= wr_lvl;
  end
  assign lvl = lvl_q;

  generate
    if (IS_LEVEL) begin : g_level
      logic unused_level_in;
      assign unused_level_in = ^{wr_flag, vec_clr};
      assign flag = req_in;
    end else begin : g_edge
      logic req_prev, flag_q, rise, sw_set, sw_clr;
      assign rise   = req_in & ~req_prev;
      assign sw_set = wr_sel & wr_flag;
      assign sw_clr = wr_sel & ~wr_flag;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          req_prev <= 1'b0;
          flag_q   <= 1'b0;
        end else begin
          req_prev <= req_in;
          if (sw_clr || vec_clr)     flag_q <= 1'b0;
          else if (rise || sw_set)   flag_q <= 1'b1;
        end
      end
      assign flag = flag_q;

      AST_SWCLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> !flag_q); // R6
      AST_VECCLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        vec_clr |=> !flag_q); // R8
      AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !wr_sel && !vec_clr) |=> flag_q); // R3
    end
  endgenerate
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
#(
  parameter int NSRC  = 4,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]       pend,
  input  lvl_t [NSRC-1:0]       lvls,
  output logic                  win_valid,
  output logic [IDX_W-1:0]      win_idx,
  output lvl_t                  win_lvl,
  output logic [NSRC-1:0]       grant
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = LVL_OFF;
    // strict compare: level 7 never wins, earlier index keeps a tie
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (lvls[i] < win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = lvls[i];
      end
    end
    grant = '0;
    if (win_valid) grant[win_idx] = 1'b1;
  end
endmodule

// File: rtl/irq_vec_mask.sv
module irq_vec_mask
  import irq_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vec_rd,
  input  logic mask_wr,
  input  lvl_t wmask,
  input  logic win_valid,
  input  lvl_t win_lvl,
  output lvl_t mask,
  output logic eligible,
  output logic cpu_irq
);
  lvl_t mask_q;
  logic irq_q, irq_drop;

  assign eligible = win_valid && below_mask(win_lvl, mask_q);
  assign irq_drop = vec_rd || mask_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= LVL_OFF;
      irq_q  <= 1'b0;
    end else begin
      if (mask_wr)                     mask_q <= wmask;
      else if (vec_rd && win_valid)    mask_q <= win_lvl;
      if (irq_drop)                    irq_q  <= 1'b0;
      else if (eligible)               irq_q  <= 1'b1;
    end
  end

  assign mask    = mask_q;
  assign cpu_irq = irq_q;

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && !irq_drop) |=> cpu_irq); // R11
  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_drop |=> !cpu_irq); // R11
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> $past(eligible)); // R10
  AST_MASK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && win_valid && !mask_wr) |=> (mask == $past(win_lvl))); // R9
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int              NSRC      = 4,
  parameter int              ADDR_W    = 4,
  parameter logic [NSRC-1:0] LEVEL_SRC = 4'b1000,
  parameter int              VEC_ADDR  = 8,
  parameter int              MASK_ADDR = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   periph_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              cpu_irq
);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]  pend, grant, wr_sel, vec_clr;
  lvl_t [NSRC-1:0]  lvls;
  logic             win_valid, eligible, vec_rd, mask_wr;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl, mask;

  assign vec_rd  = bus_rd && (bus_addr == ADDR_W'(VEC_ADDR));
  assign mask_wr = bus_wr && (bus_addr == ADDR_W'(MASK_ADDR));

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign wr_sel[i]  = bus_wr && (bus_addr == ADDR_W'(i));
      assign vec_clr[i] = vec_rd && grant[i];
      irq_src_cell #(.IS_LEVEL(LEVEL_SRC[i])) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_in  (periph_req[i]),
        .wr_sel  (wr_sel[i]),
        .wr_flag (bus_wdata[FLAG_BIT]),
        .wr_lvl  (bus_wdata[2:0]),
        .vec_clr (vec_clr[i]),
        .flag    (pend[i]),
        .lvl     (lvls[i])
      );
    end
  endgenerate

  irq_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .pend      (pend),
    .lvls      (lvls),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl),
    .grant     (grant)
  );

  irq_vec_mask u_vm (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_rd    (vec_rd),
    .mask_wr   (mask_wr),
    .wmask     (bus_wdata[2:0]),
    .win_valid (win_valid),
    .win_lvl   (win_lvl),
    .mask      (mask),
    .eligible  (eligible),
    .cpu_irq   (cpu_irq)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      for (int i = 0; i < NSRC; i++)
        if (bus_addr == ADDR_W'(i)) bus_rdata = pack_ctrl(pend[i], lvls[i]);
      if (bus_addr == ADDR_W'(VEC_ADDR))
        bus_rdata = win_valid ? 8'(win_idx) : 8'hFF;
      if (bus_addr == ADDR_W'(MASK_ADDR))
        bus_rdata = {5'b00000, mask};
    end
  end

  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (pend[win_idx] && (win_lvl != LVL_OFF))); // R7
  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_clr)); // R8
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4;
  localparam logic [3:0] A_VEC = 4'd8, A_MASK = 4'd9;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] periph_req = '0, bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       cpu_irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.NSRC(NSRC), .ADDR_W(4), .LEVEL_SRC(4'b1000)) u_dut (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq));

  function automatic logic [7:0] ctrl_img(logic f, logic [2:0] l);
    return (8'(f) << 4) | 8'(l);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge; each access is one cycle
  task automatic wr(logic [3:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d); chk(tag, d, exp);
  endtask

  task automatic t_reset;
    for (int i = 0; i < NSRC; i++) rd_chk("R1 ctrl reset", 4'(i), 8'h07);
    rd_chk("R1 mask reset", A_MASK, 8'h07);
    chk("R1 irq reset", 8'(cpu_irq), 8'h00);
    rd_chk("R1 vector none", A_VEC, 8'hFF);
  endtask

  task automatic t_layout;
    wr(4'd0, 8'hFF);
    rd_chk("R2 reserved bits zero", 4'd0, 8'h17);
    wr(4'd0, 8'h05);
    rd_chk("R2 level writable", 4'd0, 8'h05);
    wr(4'd0, 8'h07);
  endtask

  task automatic t_edge;
    wr(4'd1, 8'h03);
    periph_req[1] = 1'b1;
    @(negedge clk);
    rd_chk("R3 rise sets flag", 4'd1, ctrl_img(1'b1, 3'd3));
    chk("R10 irq raised", 8'(cpu_irq), 8'h01);
    wr(4'd1, 8'h03);
    rd_chk("R3 held line no reset", 4'd1, ctrl_img(1'b0, 3'd3));
    chk("R11 irq kept after clear", 8'(cpu_irq), 8'h01);
    wr(A_MASK, 8'h07);
    chk("R11 irq dropped by mask write", 8'(cpu_irq), 8'h00);
    wr(4'd1, 8'h13);
    rd_chk("R4 sw set", 4'd1, 8'h13);
    wr(4'd1, 8'h03);
    rd_chk("R4 sw clear", 4'd1, 8'h03);
    periph_req[1] = 1'b0;
    wr(4'd1, 8'h07);
    wr(A_MASK, 8'h07);
  endtask

  task automatic t_level;
    wr(4'd3, 8'h12);
    rd_chk("R5 write cannot set", 4'd3, 8'h02);
    periph_req[3] = 1'b1;
    rd_chk("R5 flag follows line", 4'd3, 8'h12);
    wr(4'd3, 8'h02);
    rd_chk("R5 write cannot clear", 4'd3, 8'h12);
    rd_chk("R7 vector level src", A_VEC, 8'h03);
    rd_chk("R8 level flag kept", 4'd3, 8'h12);
    rd_chk("R9 mask latched", A_MASK, 8'h02);
    chk("R10 equal level blocked", 8'(cpu_irq), 8'h00);
    wr(A_MASK, 8'h07);
    chk("R11 low right after mask write", 8'(cpu_irq), 8'h00);
    @(negedge clk);
    chk("R10 irq after unmask", 8'(cpu_irq), 8'h01);
    periph_req[3] = 1'b0;
    wr(4'd3, 8'h07);
    wr(A_MASK, 8'h07);
    chk("R11 vector read path idle", 8'(cpu_irq), 8'h00);
  endtask

  task automatic t_prio;
    wr(4'd0, 8'h15); wr(4'd1, 8'h12); wr(4'd2, 8'h12);
    rd_chk("R7 tie to lowest index", A_VEC, 8'h01);
    rd_chk("R8 edge winner cleared", 4'd1, 8'h02);
    rd_chk("R9 mask from winner", A_MASK, 8'h02);
    rd_chk("R7 next winner", A_VEC, 8'h02);
    rd_chk("R7 last winner", A_VEC, 8'h00);
    rd_chk("R7 none left", A_VEC, 8'hFF);
    wr(4'd0, 8'h17);
    rd_chk("R7 level 7 disabled", A_VEC, 8'hFF);
    wr(4'd0, 8'h07); wr(4'd1, 8'h07); wr(4'd2, 8'h07);
    wr(A_MASK, 8'h07);
  endtask

  task automatic t_mask;
    wr(A_MASK, 8'h03);
    wr(4'd0, 8'h13);
    @(negedge clk); @(negedge clk);
    chk("R10 level equal to mask blocked", 8'(cpu_irq), 8'h00);
    wr(4'd0, 8'h12);
    chk("R10 not yet", 8'(cpu_irq), 8'h00);
    @(negedge clk);
    chk("R10 level below mask", 8'(cpu_irq), 8'h01);
    rd_chk("R9 mask readback", A_MASK, 8'h03);
    rd_chk("R7 vector", A_VEC, 8'h00);
    chk("R11 vector read drops", 8'(cpu_irq), 8'h00);
    wr(4'd0, 8'h07); wr(A_MASK, 8'h07);
  endtask

  task automatic t_race;
    logic [7:0] d;
    wr(4'd0, 8'h04);
    periph_req[0] = 1'b1;
    wr(4'd0, 8'h04);
    rd_chk("R6 sw clear beats rise", 4'd0, 8'h04);
    periph_req[0] = 1'b0;
    wr(4'd1, 8'h11);
    periph_req[1] = 1'b1;
    rd(A_VEC, d);
    chk("R7 race vector", d, 8'h01);
    rd_chk("R8 vector clear beats rise", 4'd1, 8'h01);
    periph_req[1] = 1'b0;
    wr(4'd1, 8'h07); wr(A_MASK, 8'h07);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_layout;
    t_edge;
    t_level;
    t_prio;
    t_mask;
    t_race;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule